// File: doc/BRIEF.md
# Time-of-Day Counter with Fractional Nanosecond Step

This block keeps a free-running time of day for precision timestamping. Every cycle of its timer clock it advances a nanoseconds count by a programmable whole-nanosecond step. A 16-bit binary fraction step is accumulated alongside it, and each carry out of that accumulator adds one more nanosecond. When the nanoseconds reach one billion they wrap and a 48-bit seconds count steps. Software sets the rate by rewriting the two step values. A small register bus writes the time words and applies signed one-shot offsets.

The seconds count is written as two independent words, a high word and a low word, with no staging. A write lands immediately, so a nanosecond carry can fall between two software writes. Reading is made consistent differently. A read of the seconds-low word captures the nanoseconds and seconds-high values into shadow registers, and the following reads of those two words return that capture.

Top module: `tod_clock`

## Requirements
- R1: After the synchronous reset the time, the fraction accumulator, both step values, the shadows and the read data are zero, so the time stays still until a step is programmed.
- R2: On each cycle with no time write and no nonzero adjust, the nanoseconds advance by the active whole step plus one when the 16-bit fraction accumulator, advanced by the active fraction step, carries out.
- R3: A write to offset 4 (bits 7:0) sets the whole step and copies the fraction step staged by an earlier write to offset 3 (bits 15:0) into use. The new pair governs the cycles after the offset-4 write. A write to offset 3 alone does not change the rate.
- R4: When an advance brings the nanoseconds to 1,000,000,000 or above, one billion is subtracted and the 48-bit seconds count increments, carrying from bit 31 into bit 32.
- R5: Writes land on the cycle after the write with no staging. Offset 0 sets seconds bits 47:32 from wdata[15:0], offset 1 sets seconds bits 31:0, and offset 2 sets the nanoseconds from wdata[29:0]. On the cycle of any of these writes the other time fields and the fraction hold.
- R6: A write to offset 5 applies a one-shot offset: wdata[31]=1 subtracts and 0 adds the magnitude wdata[29:0]. The result is normalised across the one-billion boundary by borrowing from or carrying into the seconds, and the time does not advance on that cycle.
- R7: A write to offset 5 with a zero magnitude has no effect; the time advances as on an idle cycle.
- R8: rdata is valid the cycle after rd_en and is zero after a cycle without rd_en. Offset 1 returns the live seconds bits 31:0 and captures the nanoseconds and seconds bits 47:32 into shadows. Offsets 0 and 2 return those shadows, zero-extended. Offset 3 returns the staged fraction step, offset 4 the active whole step, and other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bound checker checks the following on every cycle:
- zero steps keep the time frozen;
- an advance never leaves the nanoseconds at or above one billion when they started below it;
- a drop in the nanoseconds on an advance comes with exactly one seconds increment;
- a whole-step write lands on the next cycle;
- a seconds-high write lands on the next cycle;
- the read data is zero after an idle bus cycle.

The following can only be shown by the bench's scenarios, using its behavioural model:
- the fraction carry pattern;
- the borrow and carry of large signed offsets;
- a zero-magnitude adjust being ignored;
- the consistency of the shadow reads;
- the carry of the seconds from the low word into the high word.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Register offsets on the bus
  typedef enum logic [2:0] {
    OFS_SEC_HI = 3'd0,
    OFS_SEC_LO = 3'd1,
    OFS_NSEC   = 3'd2,
    OFS_FRINC  = 3'd3,
    OFS_NSINC  = 3'd4,
    OFS_ADJUST = 3'd5
  } tod_ofs_e;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;
endpackage

// File: rtl/tod_frac_acc.sv
module tod_frac_acc #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [FRAC_W-1:0] step,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, step};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (advance) acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [INC_W-1:0]  ns_step,
  input  logic              carry,
  output logic              advance,
  output logic [NS_W-1:0]   ns_q,
  output logic [SEC_W-1:0]  sec_q
);
  localparam int SEC_HI_W = SEC_W - 32;
  localparam int SW       = NS_W + 3;
  localparam logic [NS_W:0]          WRAP_T   = (NS_W+1)'(NS_PER_SEC);
  localparam logic signed [SW-1:0]   WRAP_S   = SW'(NS_PER_SEC);
  localparam logic signed [SW-1:0]   WRAP2_S  = SW'(2 * NS_PER_SEC);
  localparam logic signed [SW-1:0]   NWRAP_S  = -WRAP_S;

  logic wr_hi, wr_lo, wr_ns, adj_act, adj_neg;
  logic [NS_W-1:0]  adj_mag;
  logic [NS_W:0]    tick_sum;
  logic signed [SW-1:0] base_s, mag_s, adj_val;
  logic [NS_W-1:0]  ns_n;
  logic [SEC_W-1:0] sec_n;
  logic unused_bits;

  assign unused_bits = ^wdata[DATA_W-2:NS_W];

  assign wr_hi   = wr_en && (addr == OFS_SEC_HI);
  assign wr_lo   = wr_en && (addr == OFS_SEC_LO);
  assign wr_ns   = wr_en && (addr == OFS_NSEC);
  assign adj_mag = wdata[NS_W-1:0];
  assign adj_neg = wdata[DATA_W-1];
  assign adj_act = wr_en && (addr == OFS_ADJUST) && (|adj_mag);
  assign advance = !(wr_hi || wr_lo || wr_ns || adj_act);

  assign tick_sum = {1'b0, ns_q} + (NS_W+1)'(ns_step) + (NS_W+1)'(carry);
  assign base_s   = signed'({3'b000, ns_q});
  assign mag_s    = signed'({3'b000, adj_mag});
  assign adj_val  = adj_neg ? (base_s - mag_s) : (base_s + mag_s);

  always_comb begin
    ns_n  = ns_q;
    sec_n = sec_q;
    if (advance) begin
      if (tick_sum >= WRAP_T) begin
        ns_n  = NS_W'(tick_sum - WRAP_T);
        sec_n = sec_q + SEC_W'(1);
      end else begin
        ns_n  = tick_sum[NS_W-1:0];
      end
    end else if (wr_hi) begin
      sec_n = {wdata[SEC_HI_W-1:0], sec_q[31:0]};
    end else if (wr_lo) begin
      sec_n = {sec_q[SEC_W-1:32], wdata[31:0]};
    end else if (wr_ns) begin
      ns_n  = wdata[NS_W-1:0];
    end else begin
      if (adj_val >= WRAP2_S) begin
        ns_n  = NS_W'(adj_val - WRAP2_S);
        sec_n = sec_q + SEC_W'(2);
      end else if (adj_val >= WRAP_S) begin
        ns_n  = NS_W'(adj_val - WRAP_S);
        sec_n = sec_q + SEC_W'(1);
      end else if (adj_val < NWRAP_S) begin
        ns_n  = NS_W'(adj_val + WRAP2_S);
        sec_n = sec_q - SEC_W'(2);
      end else if (adj_val[SW-1]) begin
        ns_n  = NS_W'(adj_val + WRAP_S);
        sec_n = sec_q - SEC_W'(1);
      end else begin
        ns_n  = NS_W'(adj_val);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q  <= ns_n;
      sec_q <= sec_n;
    end
  end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   ns_live,
  input  logic [SEC_W-1:0]  sec_live,
  output logic [FRAC_W-1:0] sub_step,
  output logic [INC_W-1:0]  ns_step,
  output logic [DATA_W-1:0] rdata
);
  localparam int SEC_HI_W = SEC_W - 32;

  logic [FRAC_W-1:0]   staged_q;
  logic [NS_W-1:0]     sh_ns_q;
  logic [SEC_HI_W-1:0] sh_hi_q;
  logic [DATA_W-1:0]   rd_val;
  logic unused_bits;

  assign unused_bits = ^wdata[DATA_W-1:FRAC_W];

  always_comb begin
    case (addr)
      OFS_SEC_HI: rd_val = DATA_W'(sh_hi_q);
      OFS_SEC_LO: rd_val = sec_live[31:0];
      OFS_NSEC:   rd_val = DATA_W'(sh_ns_q);
      OFS_FRINC:  rd_val = DATA_W'(staged_q);
      OFS_NSINC:  rd_val = DATA_W'(ns_step);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      sub_step <= '0;
      ns_step  <= '0;
      sh_ns_q  <= '0;
      sh_hi_q  <= '0;
      rdata    <= '0;
    end else begin
      if (wr_en && addr == OFS_FRINC) staged_q <= wdata[FRAC_W-1:0];
      if (wr_en && addr == OFS_NSINC) begin
        ns_step  <= wdata[INC_W-1:0];
        sub_step <= staged_q;
      end
      if (rd_en && addr == OFS_SEC_LO) begin
        sh_ns_q <= ns_live;
        sh_hi_q <= sec_live[SEC_W-1:32];
      end
      rdata <= rd_en ? rd_val : '0;
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [FRAC_W-1:0] sub_step;
  logic [INC_W-1:0]  ns_step;
  logic              carry, advance;
  logic [NS_W-1:0]   ns_q;
  logic [SEC_W-1:0]  sec_q;

  tod_frac_acc #(.FRAC_W(FRAC_W)) frac_i (
    .clk(clk), .rst(rst), .advance(advance), .step(sub_step), .carry(carry)
  );

  tod_time_core #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .DATA_W(DATA_W)) core_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ns_step(ns_step), .carry(carry), .advance(advance),
    .ns_q(ns_q), .sec_q(sec_q)
  );

  tod_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .ns_live(ns_q), .sec_live(sec_q), .sub_step(sub_step), .ns_step(ns_step),
    .rdata(rdata)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NS_W-1:0]   ns_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [INC_W-1:0]  ns_step,
  input logic [FRAC_W-1:0] sub_step
);
  localparam logic [NS_W-1:0] WRAP = NS_W'(1_000_000_000);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2
  frozen_when_zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !wr_en && ns_step == '0 && sub_step == '0) |=> ($stable(ns_q) && $stable(sec_q)));

  // R4
  ns_stays_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!wr_en) && $past(ns_q) < WRAP) |-> (ns_q < WRAP));

  // R4
  wrap_steps_seconds_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!wr_en) && ns_q < $past(ns_q)) |-> (sec_q == $past(sec_q) + SEC_W'(1)));

  // R3
  step_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_en && addr == 3'd4)) |-> (ns_step == $past(wdata[INC_W-1:0])));

  // R5
  sec_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_en && addr == 3'd0)) |-> (sec_q[SEC_W-1:32] == $past(wdata[SEC_W-33:0])));

  // R8
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!rd_en)) |-> (rdata == '0));
endmodule

bind tod_clock tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ns_q(ns_q), .sec_q(sec_q), .ns_step(ns_step), .sub_step(sub_step)
);

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int    checks = 0;
  int    errors = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint m_ns, m_sec, m_frac, m_sub, m_staged, m_inc, m_shns, m_shsh;
  logic [31:0] m_rdata;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  localparam longint BILLION = 64'd1_000_000_000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;

  always #10 clk = ~clk;

  tod_clock dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ns = 0; m_sec = 0; m_frac = 0; m_sub = 0; m_staged = 0;
      m_inc = 0; m_shns = 0; m_shsh = 0; m_rdata = '0;
    end else begin
      longint nr, mag, t, f;
      bit hold;
      nr = 0;
      if (rd_en) begin
        case (addr)
          3'd0: nr = m_shsh;
          3'd1: nr = m_sec & 64'hFFFF_FFFF;
          3'd2: nr = m_shns;
          3'd3: nr = m_staged;
          3'd4: nr = m_inc;
          default: nr = 0;
        endcase
        if (addr == 3'd1) begin
          m_shns = m_ns;
          m_shsh = m_sec >> 32;
        end
      end
      m_rdata = nr[31:0];
      mag  = longint'(wdata & 32'h3FFF_FFFF);
      hold = wr_en && (addr <= 3'd2 || (addr == 3'd5 && mag != 0));
      if (!hold) begin
        f = m_frac + m_sub;
        m_frac = f % 65536;
        t = m_ns + m_inc + f / 65536;
        while (t >= BILLION) begin t -= BILLION; m_sec += 1; end
        m_ns = t;
      end else if (addr == 3'd0) begin
        m_sec = (longint'(wdata & 32'hFFFF) << 32) | (m_sec & 64'hFFFF_FFFF);
      end else if (addr == 3'd1) begin
        m_sec = (m_sec & ~64'hFFFF_FFFF) | longint'(wdata);
      end else if (addr == 3'd2) begin
        m_ns = mag;
      end else begin
        t = wdata[31] ? m_ns - mag : m_ns + mag;
        while (t >= BILLION) begin t -= BILLION; m_sec += 1; end
        while (t < 0) begin t += BILLION; m_sec -= 1; end
        m_ns = t;
      end
      m_sec = m_sec & SEC_MASK;
      if (wr_en && addr == 3'd4) begin
        m_inc = longint'(wdata & 32'hFF);
        m_sub = m_staged;
      end
      if (wr_en && addr == 3'd3) m_staged = longint'(wdata & 32'hFFFF);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s: rdata=%0h expected %0h", cur_req, rdata, m_rdata);
      end
    end
  end

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1;

    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      expect_eq("R1", v, 32'h0);
    end
    idle(5);
    rd(3'd1, v); expect_eq("R1", v, 32'h0);
    rd(3'd2, v); expect_eq("R1", v, 32'h0);

    // frozen time: direct word writes and shadow reads
    cur_req = "R5";
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h89AB_CDEF);
    wr(3'd2, 32'd123);
    rd(3'd1, v); expect_eq("R5", v, 32'h89AB_CDEF);
    rd(3'd0, v); expect_eq("R8", v, 32'h0000_FFFF);
    rd(3'd2, v); expect_eq("R5", v, 32'd123);
    rd(3'd7, v); expect_eq("R8", v, 32'h0);
    rd(3'd5, v); expect_eq("R8", v, 32'h0);

    // signed adjust with borrow and carry
    cur_req = "R6";
    wr(3'd5, 32'd900_000_000);
    rd(3'd1, v); rd(3'd2, v); expect_eq("R6", v, 32'd900_000_123);
    wr(3'd5, 32'h8000_0000 | 32'd1_000_000_000);
    rd(3'd1, v); expect_eq("R6", v, 32'h89AB_CDEE);
    rd(3'd2, v); expect_eq("R6", v, 32'd900_000_123);
    wr(3'd5, 32'd200_000_000);
    rd(3'd1, v); expect_eq("R6", v, 32'h89AB_CDEF);
    rd(3'd2, v); expect_eq("R6", v, 32'd100_000_123);

    // staging alone does not change the rate
    cur_req = "R3";
    wr(3'd3, 32'h4000);
    idle(5);
    rd(3'd3, v); expect_eq("R3", v, 32'h4000);
    rd(3'd1, v); rd(3'd2, v); expect_eq("R3", v, 32'd100_000_123);
    wr(3'd4, 32'd20);
    rd(3'd4, v); expect_eq("R3", v, 32'd20);

    cur_req = "R2";
    for (int i = 0; i < 40; i++) begin
      rd(3'd1, v); rd(3'd2, v);
    end

    // seconds carry from low word to high word
    cur_req = "R4";
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd999_999_900);
    idle(10);
    rd(3'd1, v); rd(3'd0, v); rd(3'd2, v);

    cur_req = "R7";
    wr(3'd5, 32'h0);
    wr(3'd5, 32'h8000_0000);
    rd(3'd1, v); rd(3'd2, v);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: begin cur_req = "R8"; rd(lfsr[5:3], v); end
        3'd3: begin cur_req = "R5"; wr(lfsr[4:3] == 2'd0 ? 3'd0 : 3'd2, lfsr); end
        3'd4: begin cur_req = "R6"; wr(3'd5, lfsr & 32'h8FFF_FFFF); end
        3'd5: begin cur_req = "R7"; wr(3'd5, lfsr & 32'h8000_0000); end
        3'd6: begin cur_req = "R3"; wr(3'd3, lfsr); wr(3'd4, lfsr >> 8); end
        default: begin cur_req = "R2"; idle(int'(lfsr[6:3])); end
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule